// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short run of instruction bytes ready for a byte-wide instruction consumer. It reads them ahead of time from a 16-bit memory fetch port. Up to six bytes are held. The block requests a new fetch only when there is room for a full word and no operand transfer is waiting for the bus. It forms the 20-bit fetch address from a 16-bit segment and a 16-bit offset. It then hands the bytes out, oldest first, through a valid/pop handshake.

When the consumer takes a control transfer, it pulses a flush together with a new segment and offset. The queue is emptied and fetching restarts at the new place. A fetch that was already issued when the flush came is allowed to finish on the bus, but its data is thrown away. Every cycle the block reports a two-bit status describing what happened to the queue on the previous clock edge.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most 6 bytes. `byte_out` always shows the oldest held byte, and bytes leave in the exact order of their addresses in the fetch stream.
- R2: `mem_req` rises only after a cycle in which at most 4 bytes were held, `opnd_pend` was low and `flush` was low. With 5 or 6 bytes held, no request starts.
- R3: A fetch at an even address has `mem_two`=1. It supplies two bytes: `mem_data[7:0]` first, then `mem_data[15:8]`. The offset then advances by 2. A fetch at an odd address has `mem_two`=0. It supplies one byte, taken from `mem_data[15:8]`, and the offset advances by 1.
- R4: `mem_addr` equals the segment times 16 plus the offset, truncated to 20 bits.
- R5: The offset advances modulo 65536. It never carries into the segment.
- R6: A cycle with `flush`=1 empties the queue (`byte_valid` is low in the next cycle). The next fetch uses `flush_seg`/`flush_ofs`.
- R7: Data returned for a fetch that was outstanding when a flush occurred is never written into the queue.
- R8: Once `mem_req` is high, it stays high until a cycle with `mem_ack`=1, whatever `opnd_pend` does. `opnd_go` is high only while `opnd_pend` is high and no fetch is outstanding.
- R9: `qstat` reports the previous edge's action: 2'b00 no byte taken, 2'b01 byte taken with `pop_first`=1, 2'b11 byte taken with `pop_first`=0, 2'b10 flush. A flush takes precedence over a pop in the same cycle.
- R10: A pop while the queue is empty is ignored: `qstat` reads 2'b00 and no later byte is lost.
- R11: After reset the queue is empty, `qstat` is 2'b00, `mem_req` is low, and the first fetch goes to segment 16'hFFFF, offset 0 (address 20'hFFFF0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard queue and restart at new address |
| flush_seg | input | 16 | Segment loaded on flush |
| flush_ofs | input | 16 | Offset loaded on flush |
| opnd_pend | input | 1 | An operand transfer is waiting for the bus |
| opnd_go | output | 1 | Operand transfer may start (no fetch outstanding) |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | 20 | Physical fetch address |
| mem_two | output | 1 | Fetch returns two bytes (even address) |
| mem_ack | input | 1 | Fetch data valid on mem_data |
| mem_data | input | 16 | Fetch data word |
| pop | input | 1 | Consumer takes the byte on byte_out |
| pop_first | input | 1 | Byte being taken is a first opcode byte |
| byte_valid | output | 1 | Queue holds at least one byte |
| byte_out | output | 8 | Oldest queued byte |
| qstat | output | 2 | Queue status for the previous edge |

## Verification
Two pairs of actions can meet in one cycle. A flush can coincide with a pop. A flush can also fall while a fetch is outstanding, so that the fetch's acknowledge arrives after the queue has restarted. The bench provokes the first by raising `flush` and `pop` on the same edge. It expects `qstat` 2'b10 and an empty queue. It provokes the second by stalling the memory model, flushing, and then acknowledging the old request by hand. It requires that no byte appears, that the next request carries the new address, and that the popped bytes come from the new stream.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_BUSY  = 2'd1,
    FS_DRAIN = 2'd2
  } fetch_st_t;

  localparam logic [1:0] QS_NONE  = 2'b00;
  localparam logic [1:0] QS_FIRST = 2'b01;
  localparam logic [1:0] QS_FLUSH = 2'b10;
  localparam logic [1:0] QS_NEXT  = 2'b11;
endpackage

// File: rtl/pq_addr_gen.sv
module pq_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFS_W-1:0] RST_OFS = '0,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEG_W-1:0]  load_seg,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic              advance,
  output logic [ADDR_W-1:0] phys,
  output logic              ofs_odd
);
  logic [SEG_W-1:0] seg_q;
  logic [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0] step;

  // odd offset moves by one byte, even by a full word; wraps inside OFS_W
  assign step    = ofs_q[0] ? OFS_W'(1) : OFS_W'(2);
  assign ofs_odd = ofs_q[0];
  assign phys    = {seg_q, {SHIFT{1'b0}}} + {{(ADDR_W-OFS_W){1'b0}}, ofs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= RST_SEG;
      ofs_q <= RST_OFS;
    end else if (load) begin
      seg_q <= load_seg;
      ofs_q <= load_ofs;
    end else if (advance) begin
      ofs_q <= ofs_q + step;
    end
  end

  assert_seg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> (seg_q == $past(seg_q)));
endmodule

// File: rtl/pq_byte_store.sv
module pq_byte_store #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [1:0]    wr_n,
  input  logic [7:0]    wr_b0,
  input  logic [7:0]    wr_b1,
  input  logic          rd,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] head_q, tail_q, tail_p1;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tail_p1 = nxt(tail_q);
  assign rd_data = mem[head_q];
  assign count   = count_q;

  // storage has no reset so it maps onto plain RAM cells
  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) mem[tail_q]  <= wr_b0;
    if (wr_n == 2'd2) mem[tail_p1] <= wr_b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (rd) head_q <= nxt(head_q);
      case (wr_n)
        2'd1:    tail_q <= tail_p1;
        2'd2:    tail_q <= nxt(tail_p1);
        default: tail_q <= tail_q;
      endcase
      count_q <= count_q + CW'(wr_n) - CW'(rd);
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  assert_no_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
    rd |-> (count_q != '0));
endmodule

// File: rtl/pq_fetch_ctrl.sv
module pq_fetch_ctrl
  import pq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              opnd_pend,
  input  logic [CW-1:0]     count,
  input  logic [ADDR_W-1:0] phys,
  input  logic              ofs_odd,
  input  logic              mem_ack,
  input  logic [15:0]       mem_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_two,
  output logic [1:0]        wr_n,
  output logic [7:0]        wr_b0,
  output logic [7:0]        wr_b1,
  output logic              advance,
  output logic              opnd_go
);
  localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);

  fetch_st_t st_q;
  logic room, accept;

  assign room    = (count <= ROOM_MAX);
  assign accept  = (st_q == FS_BUSY) && mem_ack && !flush;
  assign advance = accept;
  assign wr_n    = accept ? (mem_two ? 2'd2 : 2'd1) : 2'd0;
  // single byte at an odd address sits on the upper lane
  assign wr_b0   = mem_two ? mem_data[7:0] : mem_data[15:8];
  assign wr_b1   = mem_data[15:8];
  assign opnd_go = opnd_pend && (st_q == FS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FS_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_two  <= 1'b0;
    end else begin
      case (st_q)
        FS_IDLE: begin
          if (!flush && room && !opnd_pend) begin
            st_q     <= FS_BUSY;
            mem_req  <= 1'b1;
            mem_addr <= phys;
            mem_two  <= !ofs_odd;
          end
        end
        FS_BUSY: begin
          if (mem_ack) begin
            st_q    <= FS_IDLE;
            mem_req <= 1'b0;
          end else if (flush) begin
            st_q <= FS_DRAIN;
          end
        end
        FS_DRAIN: begin
          if (mem_ack) begin
            st_q    <= FS_IDLE;
            mem_req <= 1'b0;
          end
        end
        default: begin
          st_q    <= FS_IDLE;
          mem_req <= 1'b0;
        end
      endcase
    end
  end

  assert_req_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(room && !opnd_pend && !flush));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);
  assert_drain_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_DRAIN) |-> (count == '0 || !$past(flush)) );
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
  parameter logic [OFS_W-1:0] RST_OFS = 16'h0000,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SEG_W-1:0]  flush_seg,
  input  logic [OFS_W-1:0]  flush_ofs,
  input  logic              opnd_pend,
  output logic              opnd_go,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_two,
  input  logic              mem_ack,
  input  logic [15:0]       mem_data,
  input  logic              pop,
  input  logic              pop_first,
  output logic              byte_valid,
  output logic [7:0]        byte_out,
  output logic [1:0]        qstat
);
  logic [ADDR_W-1:0] phys;
  logic              ofs_odd, advance, pop_ok;
  logic [1:0]        wr_n;
  logic [7:0]        wr_b0, wr_b1;
  logic [CW-1:0]     count;

  assign byte_valid = (count != '0);
  assign pop_ok     = pop && byte_valid && !flush;

  pq_addr_gen #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT),
    .RST_SEG(RST_SEG), .RST_OFS(RST_OFS)
  ) u_addr (
    .clk(clk), .rst(rst), .load(flush), .load_seg(flush_seg),
    .load_ofs(flush_ofs), .advance(advance), .phys(phys), .ofs_odd(ofs_odd)
  );

  pq_fetch_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .opnd_pend(opnd_pend),
    .count(count), .phys(phys), .ofs_odd(ofs_odd), .mem_ack(mem_ack),
    .mem_data(mem_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_two(mem_two), .wr_n(wr_n), .wr_b0(wr_b0), .wr_b1(wr_b1),
    .advance(advance), .opnd_go(opnd_go)
  );

  pq_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clear(flush), .wr_n(wr_n), .wr_b0(wr_b0),
    .wr_b1(wr_b1), .rd(pop_ok), .rd_data(byte_out), .count(count)
  );

  always_ff @(posedge clk) begin
    if (rst)         qstat <= QS_NONE;
    else if (flush)  qstat <= QS_FLUSH;
    else if (pop_ok) qstat <= pop_first ? QS_FIRST : QS_NEXT;
    else             qstat <= QS_NONE;
  end

  assert_addr_form_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (mem_addr == $past(phys)));
  assert_width_pick_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_two == !mem_addr[0]));
  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> !byte_valid);
  assert_flush_code_R9: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (qstat == QS_FLUSH));
endmodule

// File: tb/sim_prefetch_queue.sv
`timescale 1ns/1ps
module sim_prefetch_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0, flush_ofs = '0;
  logic        opnd_pend = 1'b0;
  logic        opnd_go, mem_req, mem_two, byte_valid;
  logic [19:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_data = '0;
  logic        pop = 1'b0, pop_first = 1'b0;
  logic [7:0]  byte_out;
  logic [1:0]  qstat;

  int total = 0;
  int fails = 0;
  bit go = 1'b0;
  int lat = 0;
  int cnt = 0;

  always #2.5 clk = ~clk;

  prefetch_queue u0 (
    .clk(clk), .rst(rst), .flush(flush), .flush_seg(flush_seg),
    .flush_ofs(flush_ofs), .opnd_pend(opnd_pend), .opnd_go(opnd_go),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_two(mem_two),
    .mem_ack(mem_ack), .mem_data(mem_data), .pop(pop), .pop_first(pop_first),
    .byte_valid(byte_valid), .byte_out(byte_out), .qstat(qstat)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] bval(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]};
  endfunction

  // memory model: answers after lat idle cycles, lower lane junk on odd fetches
  always @(negedge clk) begin
    if (go) begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ack  = 1'b1;
          mem_data = mem_two ? {bval(mem_addr + 20'd1), bval(mem_addr)}
                             : {bval(mem_addr), 8'hEE};
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
    flush = 1'b1; flush_seg = s; flush_ofs = o;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!mem_req && n < 60) begin @(negedge clk); n++; end
    check(mem_req, tag, {31'd0, mem_req}, 32'd1);
  endtask

  task automatic pop_expect(input bit first, input logic [7:0] exp, input string tag);
    int n = 0;
    while (!byte_valid && n < 60) begin @(negedge clk); n++; end
    check(byte_valid && byte_out == exp, tag, {24'd0, byte_out}, {24'd0, exp});
    pop = 1'b1; pop_first = first;
    @(negedge clk);
    pop = 1'b0; pop_first = 1'b0;
    check(qstat == (first ? 2'b01 : 2'b11), "R9 qstat after pop",
          {30'd0, qstat}, first ? 32'd1 : 32'd3);
  endtask

  task automatic settle();
    go = 1'b1; lat = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!byte_valid, "R11 empty after reset", {31'd0, byte_valid}, 32'd0);
    check(qstat == 2'b00, "R11 qstat after reset", {30'd0, qstat}, 32'd0);
    check(!mem_req, "R11 no request in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    wait_req("R11 first request");
    check(mem_addr == 20'hFFFF0, "R11 reset fetch address", {12'd0, mem_addr}, 32'hFFFF0);
  endtask

  task automatic t_stream();
    logic [15:0] s = 16'h2000;
    logic [15:0] o = 16'h0100;
    settle();
    go = 1'b0;
    do_flush(s, o);
    check(qstat == 2'b10, "R9 flush code", {30'd0, qstat}, 32'd2);
    check(!byte_valid, "R6 empty after flush", {31'd0, byte_valid}, 32'd0);
    wait_req("R6 request after flush");
    check(mem_addr == phys(s, o), "R4 address form", {12'd0, mem_addr}, {12'd0, phys(s, o)});
    check(mem_two, "R3 even fetch is two bytes", {31'd0, mem_two}, 32'd1);
    go = 1'b1;
    repeat (20) @(negedge clk);
    check(!mem_req, "R2 no request when full", {31'd0, mem_req}, 32'd0);
    go = 1'b0;
    pop_expect(1'b1, bval(phys(s, o)), "R1 byte 0");
    repeat (8) @(negedge clk);
    check(!mem_req, "R2 no request with one free slot", {31'd0, mem_req}, 32'd0);
    for (int k = 1; k < 6; k++)
      pop_expect(1'b0, bval(phys(s, o + 16'(k))), "R1 ordered byte");
    repeat (3) @(negedge clk);
    check(!byte_valid, "R1 capacity is six", {31'd0, byte_valid}, 32'd0);
    check(mem_req, "R2 request with two free slots", {31'd0, mem_req}, 32'd1);
    go = 1'b1;
    for (int k = 6; k < 12; k++)
      pop_expect(k == 8, bval(phys(s, o + 16'(k))), "R1 continued stream");
  endtask

  task automatic t_odd();
    logic [15:0] s = 16'h0030;
    logic [15:0] o = 16'h0007;
    settle();
    go = 1'b0;
    do_flush(s, o);
    wait_req("R3 odd request");
    check(!mem_two && mem_addr == 20'h00307, "R3 odd fetch single byte",
          {11'd0, mem_two, mem_addr}, 32'h00307);
    lat = 2; go = 1'b1;
    for (int k = 0; k < 6; k++)
      pop_expect(k == 0, bval(phys(s, o + 16'(k))), "R3 odd lane and advance");
  endtask

  task automatic t_wrap();
    logic [15:0] s = 16'h1000;
    logic [15:0] o = 16'hFFFE;
    settle();
    go = 1'b0;
    do_flush(s, o);
    wait_req("R5 request");
    check(mem_addr == 20'h1FFFE, "R4 address near top", {12'd0, mem_addr}, 32'h1FFFE);
    go = 1'b1;
    for (int k = 0; k < 4; k++)
      pop_expect(k == 0, bval(phys(s, o + 16'(k))), "R5 offset wraps in segment");
    settle();
    go = 1'b0;
    do_flush(16'hFFFF, 16'h0010);
    wait_req("R4 request");
    check(mem_addr == 20'h00000, "R4 20-bit truncation", {12'd0, mem_addr}, 32'h0);
  endtask

  task automatic t_operand();
    settle();
    go = 1'b0;
    do_flush(16'h0400, 16'h0000);
    wait_req("R8 request");
    opnd_pend = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_req, "R8 fetch held while operand waits", {31'd0, mem_req}, 32'd1);
    check(!opnd_go, "R8 operand blocked by fetch", {31'd0, opnd_go}, 32'd0);
    go = 1'b1;
    repeat (10) @(negedge clk);
    check(opnd_go, "R8 operand released after fetch", {31'd0, opnd_go}, 32'd1);
    check(!mem_req, "R2 no request while operand pending", {31'd0, mem_req}, 32'd0);
    go = 1'b0;
    opnd_pend = 1'b0;
    wait_req("R2 request after operand");
    check(mem_addr == 20'h04002, "R3 offset advanced by two", {12'd0, mem_addr}, 32'h04002);
  endtask

  task automatic t_flush_inflight();
    settle();
    go = 1'b0;
    do_flush(16'h0500, 16'h0020);
    wait_req("R7 request");
    do_flush(16'h0600, 16'h0040);
    check(qstat == 2'b10, "R9 flush code in flight", {30'd0, qstat}, 32'd2);
    mem_ack = 1'b1; mem_data = 16'hBEEF;
    @(negedge clk);
    mem_ack = 1'b0;
    check(!byte_valid, "R7 stale response dropped", {31'd0, byte_valid}, 32'd0);
    @(negedge clk);
    check(!byte_valid, "R7 still empty", {31'd0, byte_valid}, 32'd0);
    wait_req("R6 restart request");
    check(mem_addr == 20'h06040, "R6 restart address", {12'd0, mem_addr}, 32'h06040);
    go = 1'b1;
    pop_expect(1'b1, bval(20'h06040), "R6 new stream byte 0");
    pop_expect(1'b0, bval(20'h06041), "R6 new stream byte 1");
  endtask

  task automatic t_same_cycle();
    settle();
    go = 1'b0;
    flush = 1'b1; flush_seg = 16'h0700; flush_ofs = 16'h0010;
    pop = 1'b1; pop_first = 1'b1;
    @(negedge clk);
    flush = 1'b0; pop = 1'b0; pop_first = 1'b0;
    check(qstat == 2'b10, "R9 flush beats pop", {30'd0, qstat}, 32'd2);
    check(!byte_valid, "R6 flush with pop empties", {31'd0, byte_valid}, 32'd0);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    check(qstat == 2'b00, "R10 empty pop gives no-take code", {30'd0, qstat}, 32'd0);
    check(!byte_valid, "R10 still empty", {31'd0, byte_valid}, 32'd0);
    go = 1'b1;
    pop_expect(1'b1, bval(20'h07010), "R10 first byte not lost");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_stream();
    t_odd();
    t_wrap();
    t_operand();
    t_flush_inflight();
    t_same_cycle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule